// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Mask

This block gathers sixteen level-sensitive interrupt requests for a small processor core. Each request has its own 3-bit urgency level held in a register, where 0 is the most urgent and 7 is the least. A sequencer walks the sources one per clock cycle and picks the most urgent pending request that passes a 3-bit mask. After a full pass, if such a request was found, the block raises one request line to the core.

Software uses a byte-wide register bus. Reading the vector register returns the winning source, drops the core request and loads the mask with the winner's level, so only more urgent sources can interrupt the handler. Any write to the mask drops the core request and starts a new resolution pass. The level registers are read and written on the same bus.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the mask register reads 0xE0 (mask 7), every level register reads 0x07, the vector register reads 0x00 and `core_irq` is low.
- R2: The mask sits in bits [7:5] of the mask register at address 1. Bits [4:0] read as zero and ignore writes.
- R3: With a mask of 0, no request is ever accepted.
- R4: A pending source is accepted only when its level is strictly below the mask. A level of 7 is never accepted.
- R5: Among eligible sources, the lowest level wins. Between sources with equal levels, the lower source index wins.
- R6: `core_irq` rises only after a resolution pass has covered all sources, which is no earlier than 16 cycles after the mask write that started the pass.
- R7: Any write to the mask register, whatever its value, leaves `core_irq` low on the next cycle.
- R8: A mask write starts a new pass, and the result of that pass reflects the requests present during it.
- R9: When a source has been accepted, reading the vector register at address 0 returns bit 7 set and the source index in bits [3:0]. The read loads the mask with the winner's level and drops `core_irq`, which then stays low until a later mask write starts and completes a pass.
- R10: Reading the vector register while no source is accepted returns 0x00 and leaves the mask unchanged.
- R11: The level register of source i sits at address 16+i. Its level is in bits [2:0], the other bits read as zero, and a write stores only bits [2:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 16 | Level-sensitive interrupt requests, one bit per source |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_sel` is high |
| core_irq | output | 1 | Interrupt request to the core |

## Verification
The bench targets the comparison boundary where the level equals the mask; a design using less-or-equal would wrongly accept that source. It also targets sources that share a level, where a scan keeping the last match instead of the first would return the higher index. Further cases are level 7 under the widest mask, and a mask of 0 with every source pending; both must stay silent. The timing cases check that the core request stays low halfway through a pass, that it drops on a mask write rewriting the same value, and that it stays low after a vector read, because a design that rescans by itself would raise it again.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVL_W    = 3;
  localparam int MASK_LSB = 5;
  localparam int DATA_W   = 8;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_LOWEST = lvl_t'(7);
endpackage

// File: rtl/prio_level_bank.sv
module prio_level_bank
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  lvl_t                   wr_lvl,
  output logic [N_SRC*LVL_W-1:0] lvl_flat
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
    lvl_t lvl_q;
    logic sel_en;
    assign sel_en = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_q <= LVL_LOWEST;
      else if (sel_en) lvl_q <= wr_lvl;
    end
    assign lvl_flat[i*LVL_W +: LVL_W] = lvl_q;
  end
endmodule

// File: rtl/prio_scan_seq.sv
module prio_scan_seq
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   restart,
  input  logic [N_SRC-1:0]       req,
  input  logic [N_SRC*LVL_W-1:0] lvl_flat,
  input  lvl_t                   mask,
  output logic                   done,
  output logic                   hit,
  output logic [IDX_W-1:0]       hit_idx,
  output lvl_t                   hit_lvl
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SRC-1);

  logic             busy_q, busy_d;
  logic             found_q, found_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] best_idx_q, best_idx_d;
  lvl_t             best_lvl_q, best_lvl_d;
  lvl_t             cur_lvl;
  logic             elig, last;

  always_comb begin
    cur_lvl = lvl_flat[idx_q*LVL_W +: LVL_W];
    elig    = busy_q && req[idx_q] && (cur_lvl < mask) &&
              (!found_q || (cur_lvl < best_lvl_q));
    last    = (idx_q == LAST_IDX);
    hit     = found_q || elig;
    hit_idx = elig ? idx_q   : best_idx_q;
    hit_lvl = elig ? cur_lvl : best_lvl_q;
    done    = busy_q && last && !restart;
  end

  always_comb begin
    busy_d     = busy_q;
    found_d    = found_q;
    idx_d      = idx_q;
    best_idx_d = best_idx_q;
    best_lvl_d = best_lvl_q;
    if (restart) begin
      busy_d     = 1'b1;
      found_d    = 1'b0;
      idx_d      = '0;
      best_idx_d = '0;
      best_lvl_d = LVL_LOWEST;
    end else if (busy_q) begin
      found_d    = hit;
      best_idx_d = hit_idx;
      best_lvl_d = hit_lvl;
      idx_d      = last ? '0 : idx_q + 1'b1;
      busy_d     = !last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b1;
      found_q    <= 1'b0;
      idx_q      <= '0;
      best_idx_q <= '0;
      best_lvl_q <= LVL_LOWEST;
    end else begin
      busy_q     <= busy_d;
      found_q    <= found_d;
      idx_q      <= idx_d;
      best_idx_q <= best_idx_d;
      best_lvl_q <= best_lvl_d;
    end
  end
endmodule

// File: rtl/prio_mask_vec.sv
module prio_mask_vec
  import prio_irq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_wr,
  input  lvl_t             mask_wdata,
  input  logic             vec_rd,
  input  logic             done,
  input  logic             hit,
  input  logic [IDX_W-1:0] hit_idx,
  input  lvl_t             hit_lvl,
  output lvl_t             mask_q,
  output logic             irq_q,
  output logic [IDX_W-1:0] win_idx_q,
  output lvl_t             win_lvl_q
);
  lvl_t             mask_d, win_lvl_d;
  logic             irq_d;
  logic [IDX_W-1:0] win_idx_d;

  always_comb begin
    mask_d    = mask_q;
    irq_d     = irq_q;
    win_idx_d = win_idx_q;
    win_lvl_d = win_lvl_q;
    if (done && hit) begin
      irq_d     = 1'b1;
      win_idx_d = hit_idx;
      win_lvl_d = hit_lvl;
    end
    if (vec_rd && irq_q) begin
      mask_d = win_lvl_q;
      irq_d  = 1'b0;
    end
    if (mask_wr) begin
      mask_d = mask_wdata;
      irq_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= LVL_LOWEST;
      irq_q     <= 1'b0;
      win_idx_q <= '0;
      win_lvl_q <= '0;
    end else begin
      mask_q    <= mask_d;
      irq_q     <= irq_d;
      win_idx_q <= win_idx_d;
      win_lvl_q <= win_lvl_d;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int IDX_W  = $clog2(N_SRC),
  parameter int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_src,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              core_irq
);
  localparam logic [ADDR_W-1:0] ADDR_VEC  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(1);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic                   lvl_area, lvl_wr, mask_wr, vec_rd, rd_mask;
  logic [N_SRC*LVL_W-1:0] lvl_flat;
  logic                   seq_done, seq_hit;
  logic [IDX_W-1:0]       seq_idx, win_idx;
  lvl_t                   seq_lvl, mask_q, win_lvl, sel_lvl;
  logic                   irq_q;

  assign lvl_area = bus_addr[ADDR_W-1];
  assign lvl_wr   = bus_sel && bus_wr && lvl_area;
  assign mask_wr  = bus_sel && bus_wr && (bus_addr == ADDR_MASK);
  assign vec_rd   = bus_sel && !bus_wr && (bus_addr == ADDR_VEC);
  assign rd_mask  = bus_sel && !bus_wr && (bus_addr == ADDR_MASK);

  prio_level_bank #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_levels (
    .clk(clk), .rst_n(rst_n_s), .wr_en(lvl_wr),
    .wr_idx(bus_addr[IDX_W-1:0]), .wr_lvl(bus_wdata[LVL_W-1:0]),
    .lvl_flat(lvl_flat)
  );

  prio_scan_seq #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .restart(mask_wr), .req(irq_src),
    .lvl_flat(lvl_flat), .mask(mask_q), .done(seq_done), .hit(seq_hit),
    .hit_idx(seq_idx), .hit_lvl(seq_lvl)
  );

  prio_mask_vec #(.IDX_W(IDX_W)) u_mask (
    .clk(clk), .rst_n(rst_n_s), .mask_wr(mask_wr),
    .mask_wdata(bus_wdata[MASK_LSB +: LVL_W]), .vec_rd(vec_rd),
    .done(seq_done), .hit(seq_hit), .hit_idx(seq_idx), .hit_lvl(seq_lvl),
    .mask_q(mask_q), .irq_q(irq_q), .win_idx_q(win_idx), .win_lvl_q(win_lvl)
  );

  assign sel_lvl = lvl_flat[bus_addr[IDX_W-1:0]*LVL_W +: LVL_W];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (lvl_area) begin
        bus_rdata[LVL_W-1:0] = sel_lvl;
      end else if (bus_addr == ADDR_MASK) begin
        bus_rdata[MASK_LSB +: LVL_W] = mask_q;
      end else if (bus_addr == ADDR_VEC) begin
        bus_rdata[DATA_W-1] = irq_q;
        if (irq_q) bus_rdata[IDX_W-1:0] = win_idx;
      end
    end
  end

  assign core_irq = irq_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mask_wr,
  input logic              vec_rd,
  input logic              rd_mask,
  input logic              irq,
  input logic              seq_done,
  input lvl_t              mask_q,
  input lvl_t              win_lvl,
  input logic [DATA_W-1:0] rdata
);
  assert_mask_wr_drops_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> !irq);

  assert_irq_after_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(seq_done));

  assert_irq_level_below_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (win_lvl < mask_q));

  assert_mask_zero_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  assert_vec_read_loads_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && irq) |=> (!irq && mask_q == $past(win_lvl)));

  assert_idle_vec_read_keeps_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !irq && !mask_wr) |=> $stable(mask_q));

  assert_mask_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mask |-> (rdata[MASK_LSB-1:0] == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .mask_wr(mask_wr), .vec_rd(vec_rd),
  .rd_mask(rd_mask), .irq(irq_q), .seq_done(seq_done), .mask_q(mask_q),
  .win_lvl(win_lvl), .rdata(bus_rdata)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  typedef struct packed {
    logic [15:0] req;
    logic [2:0]  mask;
    logic        acc;
    logic [3:0]  idx;
    logic [2:0]  lvl;
  } vec_t;

  // source levels programmed: (i*5+3)%8 -> 3,0,5,2,7,4,1,6,3,0,5,2,7,4,1,6
  localparam vec_t VECS [NV] = '{
    '{16'h0001, 3'd7, 1'b1, 4'd0,  3'd3},  // R4 accepted
    '{16'h0003, 3'd7, 1'b1, 4'd1,  3'd0},  // R5 lower level wins
    '{16'h0202, 3'd7, 1'b1, 4'd1,  3'd0},  // R5 tie -> lower index
    '{16'h1010, 3'd7, 1'b0, 4'd0,  3'd0},  // R4 level 7 never
    '{16'h0001, 3'd3, 1'b0, 4'd0,  3'd0},  // R4 level == mask rejected
    '{16'h0001, 3'd4, 1'b1, 4'd0,  3'd3},  // R4 level < mask
    '{16'hFFFF, 3'd0, 1'b0, 4'd0,  3'd0},  // R3 mask 0
    '{16'hFFFF, 3'd1, 1'b1, 4'd1,  3'd0},  // R5 tie among level 0
    '{16'h8880, 3'd7, 1'b1, 4'd11, 3'd2},  // R5
    '{16'h4040, 3'd2, 1'b1, 4'd6,  3'd1}   // R5 tie at level 1
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_src;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        core_irq;

  int errs = 0;
  int total = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .core_irq(core_irq)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; irq_src = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 irq", 16'(core_irq), 16'h0);
    bus_read(5'd1, rd);  check("R1 mask", 16'(rd), 16'h00E0);
    bus_read(5'd17, rd); check("R1 level", 16'(rd), 16'h0007);
    bus_read(5'd0, rd);  check("R1 vector", 16'(rd), 16'h0000);

    for (int i = 0; i < 16; i++) bus_write(5'(16 + i), 8'((i * 5 + 3) % 8));
    // R11 level read-back and write of upper bits
    bus_read(5'd18, rd); check("R11 level read", 16'(rd), 16'h0005);
    bus_write(5'd20, 8'hFF);
    bus_read(5'd20, rd); check("R11 upper bits dropped", 16'(rd), 16'h0007);

    for (int v = 0; v < NV; v++) begin
      irq_src = VECS[v].req;
      bus_write(5'd1, {VECS[v].mask, 5'b0});
      repeat (20) @(negedge clk);
      check($sformatf("R4/R5 vec%0d irq", v), 16'(core_irq), 16'(VECS[v].acc));
      bus_read(5'd0, rd);
      check($sformatf("R9 vec%0d vector", v), 16'(rd),
            VECS[v].acc ? 16'({1'b1, 3'b0, VECS[v].idx}) : 16'h0);
      bus_read(5'd1, rd);
      check($sformatf("R9/R10 vec%0d mask", v), 16'(rd),
            16'({VECS[v].acc ? VECS[v].lvl : VECS[v].mask, 5'b0}));
      check($sformatf("R9 vec%0d irq dropped", v), 16'(core_irq), 16'h0);
    end

    // R2 mask field position and ignored low bits
    bus_write(5'd1, 8'hFF);
    bus_read(5'd1, rd); check("R2 mask all ones", 16'(rd), 16'h00E0);
    bus_write(5'd1, 8'h1F);
    bus_read(5'd1, rd); check("R2 low bits ignored", 16'(rd), 16'h0000);

    // R6 no request mid-pass, request after full pass
    irq_src = 16'h0001;
    bus_write(5'd1, 8'hE0);
    repeat (8) @(negedge clk);
    check("R6 low mid-pass", 16'(core_irq), 16'h0);
    repeat (12) @(negedge clk);
    check("R6 high after pass", 16'(core_irq), 16'h1);

    // R7 rewrite same mask drops irq; R8 new pass sees new requests
    irq_src = 16'h0002;
    bus_write(5'd1, 8'hE0);
    check("R7 irq dropped", 16'(core_irq), 16'h0);
    repeat (20) @(negedge clk);
    check("R8 irq after restart", 16'(core_irq), 16'h1);
    bus_read(5'd0, rd); check("R8 new winner", 16'(rd), 16'h0081);

    // R9 stays low without a mask write
    repeat (30) @(negedge clk);
    check("R9 stays low", 16'(core_irq), 16'h0);
    bus_read(5'd1, rd); check("R9 mask loaded", 16'(rd), 16'h0000);

    // R10 idle vector read
    bus_read(5'd0, rd); check("R10 idle vector", 16'(rd), 16'h0000);
    bus_read(5'd1, rd); check("R10 mask kept", 16'(rd), 16'h0000);

    finished = 1;
    finish_run();
  end
endmodule